// File: doc/BRIEF.md
# Manual Serial Pin Sequencer

This block gives software direct, bit-level control of a serial slave link. Each command carries an opcode that does one thing to the pins. It can raise or drop the chip select, issue a single serial clock pulse, or shift one byte out on one, two or four data lanes. Because of this, a controller can build any pin sequence it needs, such as the slave reset sequence (chip select low, one single-lane byte, chip select high, then four more single-lane bytes with chip select held high). The block is a sequencer of pin actions, not a framed serial master: chip select and the clock are handled by separate commands.

The manual engine owns the pins only while both its enable input and the pin-mux select input are 1. At all other times the chip select, clock and data lanes pass straight through from the automatic transaction engine. Commands arrive on a valid/ready stream. `cmd_ready` is high only while the engine owns the pins and is not busy. A source that sees ready low must hold `cmd_valid` and `cmd_data` steady until ready rises. A command is taken on the clock edge where both are high. A shift whose write bit is clear is a read: the lanes stay driven to 0 and the input lanes are sampled into a byte that software collects from `rd_data` while `rd_vld` is set.

Top module: `msc_engine`

## Requirements
- R1: The manual chip select, clock and lanes reach `cs_n`, `sck` and `dout` only while `man_en` and `mux_sel` are both 1. Otherwise those outputs equal `auto_cs_n`, `auto_sck` and `auto_dout`, `cmd_ready` is 0, and no command is taken.
- R2: A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both 1. While a clock pulse or shift is in progress (`busy` = 1), `cmd_ready` is 0, so a held command waits and then takes effect after `busy` falls.
- R3: The opcode is in command bits 11:8. Opcode 0x1 drives `cs_n` to 0 and opcode 0x0 drives it to 1, in the cycle after acceptance, without setting `busy`.
- R4: Opcode 0x2 produces exactly one serial clock pulse, keeps `busy` high for 2*HALF_DIV cycles, and leaves the data lanes at their previous value.
- R5: Opcodes 0x8, 0x9 and 0xA shift command bits 7:0 out MSB first. Opcode 0x8 uses `dout[0]` for 8 clocks. Opcode 0x9 uses `dout[1:0]` for 4 clocks, with the more significant bit of each pair on `dout[1]`. Opcode 0xA uses `dout[3:0]` for 2 clocks, with the upper nibble first.
- R6: `sck` idles low. Every serial clock lasts 2*HALF_DIV system cycles, low half first, so a shift of N clocks keeps `busy` high for N*2*HALF_DIV cycles.
- R7: Command bit 13 = 1 marks a write, and the lanes carry the data. Bit 13 = 0 marks a read: the lanes are driven 0, `din` is sampled on each rising `sck` with the same lane mapping as R5, and the byte appears on `rd_data` with `rd_vld` = 1 once the shift ends.
- R8: A one-cycle `rd_clr` pulse clears `rd_vld`. If a read completes on the same edge, the new byte is stored and `rd_vld` stays 1.
- R9: Any other opcode is accepted and has no effect on the pins, `busy` or the read data.
- R10: After reset, with the pins owned, `cs_n` = 1, `sck` = 0, `dout` = 0, `busy` = 0, `rd_vld` = 0 and `rd_data` = 0.
- R11: Clock-pulse and shift commands never change chip select. Shifts issued after opcode 0x0 run with `cs_n` held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_en | input | 1 | Manual engine enable |
| mux_sel | input | 1 | Pin mux select toward the manual engine |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_data | input | 16 | Command word (opcode, write flag, data byte) |
| rd_clr | input | 1 | Clear pulse for the read-valid flag |
| rd_data | output | 8 | Last byte captured by a read shift |
| rd_vld | output | 1 | Read byte available |
| busy | output | 1 | Clock pulse or shift in progress |
| auto_cs_n | input | 1 | Chip select from the automatic engine |
| auto_sck | input | 1 | Serial clock from the automatic engine |
| auto_dout | input | 4 | Data lanes from the automatic engine |
| cs_n | output | 1 | Chip select to the slave, active low |
| sck | output | 1 | Serial clock to the slave |
| dout | output | 4 | Output data lanes |
| din | input | 4 | Input data lanes |

## Verification
The hardest case to reach from the ports is a `rd_clr` pulse that lands on the same edge where a read shift stores its byte. The bench counts cycles from the edge where the command is accepted. Because a quad read lasts exactly 2*2*HALF_DIV cycles, it raises the clear in that final cycle and expects the flag to stay set. Back-pressure is reached by holding a chip-select command valid right behind a shift: chip select must not move until `busy` has fallen. Input lanes are driven by a bench model that advances one lane chunk after every rising `sck` it observes.

// File: rtl/msc_pkg.sv
package msc_pkg;

  localparam logic [3:0] OP_CS_HIGH = 4'h0;
  localparam logic [3:0] OP_CS_LOW  = 4'h1;
  localparam logic [3:0] OP_PULSE   = 4'h2;
  localparam logic [3:0] OP_TX1     = 4'h8;
  localparam logic [3:0] OP_TX2     = 4'h9;
  localparam logic [3:0] OP_TX4     = 4'hA;

  typedef enum logic [1:0] {
    LW_1 = 2'd0,
    LW_2 = 2'd1,
    LW_4 = 2'd2
  } lane_w_e;

  typedef struct packed {
    logic    set_cs;    // opcode touches chip select
    logic    cs_level;  // level for cs_n
    logic    start;     // opcode runs the serial clock
    logic    is_shift;  // opcode moves data
    lane_w_e lw;        // lanes used by a shift
  } op_dec_t;

endpackage

// File: rtl/msc_op_decode.sv
module msc_op_decode
  import msc_pkg::*;
(
  input  logic [3:0] op,
  output op_dec_t    dec
);

  always_comb begin
    dec = '{set_cs: 1'b0, cs_level: 1'b1, start: 1'b0, is_shift: 1'b0, lw: LW_1};
    case (op)
      OP_CS_HIGH: begin dec.set_cs = 1'b1; dec.cs_level = 1'b1; end
      OP_CS_LOW:  begin dec.set_cs = 1'b1; dec.cs_level = 1'b0; end
      OP_PULSE:   dec.start = 1'b1;
      OP_TX1:     begin dec.start = 1'b1; dec.is_shift = 1'b1; dec.lw = LW_1; end
      OP_TX2:     begin dec.start = 1'b1; dec.is_shift = 1'b1; dec.lw = LW_2; end
      OP_TX4:     begin dec.start = 1'b1; dec.is_shift = 1'b1; dec.lw = LW_4; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/msc_sck_gen.sv
module msc_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          edge_now;

  assign edge_now = run && (cnt_q == LAST);
  assign rise     = edge_now && !sck_q;
  assign fall     = edge_now && sck_q;
  assign sck      = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6: the serial clock rests low whenever no pulse or shift is running
  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck_q);

endmodule

// File: rtl/msc_lane_shift.sv
module msc_lane_shift
  import msc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  lane_w_e           load_lw,
  input  logic              load_drive,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic [3:0]        din,
  output logic [3:0]        dout,
  output logic [DATA_W-1:0] rx
);

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  lane_w_e           lw_q;
  logic              drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      lw_q  <= LW_1;
      drv_q <= 1'b0;
    end else if (load) begin
      tx_q  <= load_byte;
      lw_q  <= load_lw;
      drv_q <= load_drive;
    end else if (shift_en) begin
      case (lw_q)
        LW_1:    tx_q <= tx_q << 1;
        LW_2:    tx_q <= tx_q << 2;
        default: tx_q <= tx_q << 4;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (sample_en) begin
      case (lw_q)
        LW_1:    rx_q <= {rx_q[DATA_W-2:0], din[0]};
        LW_2:    rx_q <= {rx_q[DATA_W-3:0], din[1:0]};
        default: rx_q <= {rx_q[DATA_W-5:0], din[3:0]};
      endcase
    end
  end

  always_comb begin
    dout = 4'b0000;
    if (drv_q) begin
      case (lw_q)
        LW_1:    dout = {3'b000, tx_q[DATA_W-1]};
        LW_2:    dout = {2'b00, tx_q[DATA_W-1 -: 2]};
        default: dout = tx_q[DATA_W-1 -: 4];
      endcase
    end
  end

  assign rx = rx_q;

endmodule

// File: rtl/msc_pin_mux.sv
module msc_pin_mux (
  input  logic       own,
  input  logic       man_cs_n,
  input  logic       man_sck,
  input  logic [3:0] man_dout,
  input  logic       auto_cs_n,
  input  logic       auto_sck,
  input  logic [3:0] auto_dout,
  output logic       cs_n,
  output logic       sck,
  output logic [3:0] dout
);

  always_comb begin
    if (own) begin
      cs_n = man_cs_n;
      sck  = man_sck;
      dout = man_dout;
    end else begin
      cs_n = auto_cs_n;
      sck  = auto_sck;
      dout = auto_dout;
    end
  end

endmodule

// File: rtl/msc_engine.sv
module msc_engine
  import msc_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 8,
  parameter int CMD_W    = 16,
  parameter int OP_LSB   = 8,
  parameter int WR_BIT   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_en,
  input  logic              mux_sel,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              busy,
  input  logic              auto_cs_n,
  input  logic              auto_sck,
  input  logic [3:0]        auto_dout,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        dout,
  input  logic [3:0]        din
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              owned;
  logic              accept;
  op_dec_t           dec;
  logic [CNT_W-1:0]  n_clk;
  logic              busy_q;
  logic [CNT_W-1:0]  left_q;
  logic              shift_q;
  logic              rdop_q;
  logic              cs_q;
  logic [DATA_W-1:0] rd_q;
  logic              vld_q;
  logic              sck_m;
  logic              rise;
  logic              fall;
  logic              last_fall;
  logic [3:0]        dout_m;
  logic [DATA_W-1:0] rx;
  logic              unused_cmd_bits;

  assign unused_cmd_bits = ^cmd_data;

  assign owned     = man_en && mux_sel;
  assign cmd_ready = owned && !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign last_fall = busy_q && fall && (left_q == ONE);

  msc_op_decode u_dec (
    .op  (cmd_data[OP_LSB +: 4]),
    .dec (dec)
  );

  always_comb begin
    case (dec.lw)
      LW_1:    n_clk = CNT_W'(DATA_W);
      LW_2:    n_clk = CNT_W'(DATA_W / 2);
      default: n_clk = CNT_W'(DATA_W / 4);
    endcase
  end

  msc_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .sck   (sck_m),
    .rise  (rise),
    .fall  (fall)
  );

  msc_lane_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept && dec.is_shift),
    .load_byte  (cmd_data[DATA_W-1:0]),
    .load_lw    (dec.lw),
    .load_drive (cmd_data[WR_BIT]),
    .shift_en   (busy_q && shift_q && fall && (left_q != ONE)),
    .sample_en  (busy_q && shift_q && rise),
    .din        (din),
    .dout       (dout_m),
    .rx         (rx)
  );

  // Sequencing: chip select, clock budget and ownership of the run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      busy_q  <= 1'b0;
      left_q  <= '0;
      shift_q <= 1'b0;
      rdop_q  <= 1'b0;
    end else if (accept) begin
      if (dec.set_cs) cs_q <= dec.cs_level;
      if (dec.start) begin
        busy_q  <= 1'b1;
        left_q  <= dec.is_shift ? n_clk : ONE;
        shift_q <= dec.is_shift;
        rdop_q  <= dec.is_shift && !cmd_data[WR_BIT];
      end
    end else if (busy_q && fall) begin
      if (left_q == ONE) busy_q <= 1'b0;
      else               left_q <= left_q - 1'b1;
    end
  end

  // Read capture; a completing read beats a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else if (last_fall && shift_q && rdop_q) begin
      rd_q  <= rx;
      vld_q <= 1'b1;
    end else if (rd_clr) begin
      vld_q <= 1'b0;
    end
  end

  msc_pin_mux u_mux (
    .own       (owned),
    .man_cs_n  (cs_q),
    .man_sck   (sck_m),
    .man_dout  (dout_m),
    .auto_cs_n (auto_cs_n),
    .auto_sck  (auto_sck),
    .auto_dout (auto_dout),
    .cs_n      (cs_n),
    .sck       (sck),
    .dout      (dout)
  );

  assign busy    = busy_q;
  assign rd_data = rd_q;
  assign rd_vld  = vld_q;

  // R2: a run only begins on a handshake edge
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_valid && cmd_ready));

  // R11: chip select cannot move while a pulse or shift runs
  p_cs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cs_q));

  // R7: a new read byte only appears at the end of a run
  p_rd_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(busy_q));

  // R7: read shifts keep the manual lanes at zero
  p_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rdop_q) |-> (dout_m == 4'b0000));

  // R8: a clear with no run in flight always empties the flag
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !busy_q) |=> !vld_q);

  // R9: an unknown opcode leaves the engine idle and chip select alone
  p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.set_cs && !dec.start) |=> (!busy_q && $stable(cs_q)));

endmodule

// File: tb/tb_msc_engine.sv
module tb_msc_engine;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        man_en = 1'b0;
  logic        mux_sel = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = 16'h0000;
  logic        rd_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_vld;
  logic        busy;
  logic        auto_cs_n = 1'b1;
  logic        auto_sck = 1'b0;
  logic [3:0]  auto_dout = 4'h0;
  logic        cs_n;
  logic        sck;
  logic [3:0]  dout;
  logic [3:0]  din = 4'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msc_engine #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .man_en(man_en), .mux_sel(mux_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rd_clr(rd_clr), .rd_data(rd_data), .rd_vld(rd_vld), .busy(busy),
    .auto_cs_n(auto_cs_n), .auto_sck(auto_sck), .auto_dout(auto_dout),
    .cs_n(cs_n), .sck(sck), .dout(dout), .din(din)
  );

  // {cmd, din pattern, expected lane byte, expected read byte, clocks, read valid}
  localparam logic [47:0] VEC [0:6] = '{
    48'h28A5_00_A5_00_8_0,
    48'h293C_00_3C_00_4_0,
    48'h2AE7_00_E7_00_2_0,
    48'h0800_5A_00_5A_8_1,
    48'h0900_C6_00_C6_4_1,
    48'h0A00_9F_00_9F_2_1,
    48'h2801_00_01_00_8_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [3:0] op);
    if (op == 4'h9) return 2;
    if (op == 4'hA) return 4;
    return 1;
  endfunction

  function automatic logic [3:0] chunk(input logic [7:0] b, input int k, input int i);
    logic [7:0] s;
    if (k * (i + 1) > 8) return 4'h0;
    s = b >> (8 - k * (i + 1));
    return s[3:0] & 4'((1 << k) - 1);
  endfunction

  task automatic send(input logic [15:0] cmd);
    int guard = 0;
    while (!cmd_ready && guard < 1000) begin guard++; @(negedge clk); end
    cmd_data = cmd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_op(input logic [15:0] cmd, input logic [7:0] pat, input int clr_at,
                        output int rises, output int cyc, output logic [7:0] pins,
                        output int cslo);
    int k;
    logic prev;
    k = lanes_of(cmd[11:8]);
    rises = 0; cyc = 0; pins = 8'h00; cslo = 0;
    din = chunk(pat, k, 0);
    send(cmd);
    prev = 1'b0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (sck && !prev) begin
        pins = (pins << k) | 8'(dout & 4'((1 << k) - 1));
        if (!cs_n) cslo++;
        rises++;
        din = chunk(pat, k, rises);
      end
      prev = sck;
      rd_clr = (cyc == clr_at);
      @(negedge clk);
    end
    rd_clr = 1'b0;
  endtask

  task automatic clear_flag();
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R2) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rises, cyc, cslo, viol;
    logic [7:0] pins;
    logic [3:0] held;

    man_en = 1'b1;
    mux_sel = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state with pins owned
    chk("R10 cs_n", cs_n, 1);
    chk("R10 sck", sck, 0);
    chk("R10 dout", dout, 0);
    chk("R10 busy", busy, 0);
    chk("R10 rd_vld", rd_vld, 0);
    chk("R10 rd_data", rd_data, 0);
    chk("R2 ready when idle", cmd_ready, 1);

    // R1 ownership handover
    auto_cs_n = 1'b0; auto_sck = 1'b1; auto_dout = 4'hA;
    mux_sel = 1'b0;
    @(negedge clk);
    chk("R1 cs_n passthrough", cs_n, 0);
    chk("R1 sck passthrough", sck, 1);
    chk("R1 dout passthrough", dout, 4'hA);
    chk("R1 ready low", cmd_ready, 0);
    cmd_data = 16'h2100; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    man_en = 1'b0; mux_sel = 1'b1;
    @(negedge clk);
    chk("R1 passthrough with enable off", cs_n, 0);
    chk("R1 ready low with enable off", cmd_ready, 0);
    man_en = 1'b1;
    auto_cs_n = 1'b1; auto_sck = 1'b0; auto_dout = 4'h0;
    @(negedge clk);
    chk("R1 command while not owned ignored", cs_n, 1);
    chk("R1 busy unchanged", busy, 0);

    // R3 chip select opcodes
    send(16'h2100);
    chk("R3 cs low", cs_n, 0);
    chk("R3 no busy", busy, 0);
    send(16'h2000);
    chk("R3 cs high", cs_n, 1);

    // Table of shifts: R5 lanes, R6 timing, R7 read capture
    for (int i = 0; i < 7; i++) begin
      logic [47:0] v;
      v = VEC[i];
      clear_flag();
      run_op(v[47:32], v[31:24], 0, rises, cyc, pins, cslo);
      chk($sformatf("R5 lanes vector %0d", i), pins, v[23:16]);
      chk($sformatf("R6 clocks vector %0d", i), rises, v[7:4]);
      chk($sformatf("R6 busy cycles vector %0d", i), cyc, v[7:4] * 2 * HALF);
      chk($sformatf("R6 sck idle vector %0d", i), sck, 0);
      chk($sformatf("R7 rd_vld vector %0d", i), rd_vld, v[3:0]);
      if (v[3:0] != 0) chk($sformatf("R7 rd_data vector %0d", i), rd_data, v[15:8]);
    end

    // R4 single clock pulse keeps lanes
    held = dout;
    run_op(16'h0200, 8'h00, 0, rises, cyc, pins, cslo);
    chk("R4 one pulse", rises, 1);
    chk("R4 busy cycles", cyc, 2 * HALF);
    chk("R4 lanes unchanged", dout, held);

    // R9 unknown opcodes
    send(16'h2500);
    chk("R9 no busy", busy, 0);
    chk("R9 cs unchanged", cs_n, 1);
    chk("R9 lanes unchanged", dout, held);
    send(16'h2F01);
    chk("R9 cs unchanged 0xF", cs_n, 1);

    // R2 back-pressure: chip-select command held behind a shift
    viol = 0;
    send(16'h28FF);
    cmd_data = 16'h2100; cmd_valid = 1'b1;
    while (busy) begin
      if (!cs_n || cmd_ready) viol++;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 held command waited", viol, 0);
    chk("R2 held command applied", cs_n, 0);

    // R11 slave reset sequence: CS low, shift, CS high, four shifts
    run_op(16'h2800, 8'h00, 0, rises, cyc, pins, cslo);
    chk("R11 first shift under cs low", cslo, 8);
    send(16'h2000);
    for (int j = 0; j < 4; j++) begin
      run_op(16'h2800, 8'h00, 0, rises, cyc, pins, cslo);
      chk($sformatf("R11 shift %0d keeps cs high", j), cslo, 0);
      chk($sformatf("R11 shift %0d clocks", j), rises, 8);
    end

    // R8 clear alone, then clear on the completion edge
    run_op(16'h0A00, 8'h33, 0, rises, cyc, pins, cslo);
    chk("R8 flag set", rd_vld, 1);
    clear_flag();
    chk("R8 clear", rd_vld, 0);
    run_op(16'h0A00, 8'h6C, 4 * HALF, rises, cyc, pins, cslo);
    chk("R8 set wins over clear", rd_vld, 1);
    chk("R8 byte stored", rd_data, 8'h6C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule